// File: doc/BRIEF.md
# Memory Pattern Sweep Verifier

This block walks every location of a byte-wide memory through a simple read port and compares each byte it reads with a reference byte. The reference byte is generated from the location's address. Four reference images are available: the blank (erased) image, a checkerboard in which neighbouring cells always hold opposite values, a one-zero-per-byte diagonal, and a dense diagonal in which more than 95 percent of all bits are ones. A single wrong bit anywhere makes the whole sweep fail.

A sweep starts with a one-cycle start request that carries the image code and a stop-on-first-error choice. The block then issues one read at a time. It reports the first failing address, the bits that differed there, and a saturating count of failing locations. The usual flow is to sweep once before a stress step and once after it, then compare the two reports. Status stays unchanged between sweeps, so both results can be collected at leisure.

Top module: `mem_pattern_verifier`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, mem_req_o and fail_o are low, and fail_addr_o, fail_bits_o and err_count_o are zero.
- R2: A start_i pulse while idle begins a sweep at address 0 on the next cycle and clears fail_o, fail_addr_o, fail_bits_o and err_count_o. A start_i pulse during a sweep, and the pattern_i and stop_on_fail_i values that come with it, are ignored.
- R3: During a sweep mem_req_o is high and mem_addr_o is held until a cycle with mem_valid_i high, in which the block takes mem_data_i for that address. The address then steps by one. mem_valid_i is ignored while mem_req_o is low.
- R4: Image code 0 (erased) expects 0xFF at every address.
- R5: Image code 1 (checkerboard) expects 0x55 where address bit 0 XOR address bit ROW_BIT is 0, and 0xAA where it is 1.
- R6: Image code 2 (diagonal) expects 0xFF with only bit (address mod 8) cleared.
- R7: Image code 3 (dense diagonal) expects 0xFF, except at addresses whose bits [1:0] are 00; there bit number address[4:2] is cleared. One bit in 32 is zero, so 96.9 percent of bits are ones.
- R8: Any location whose byte differs in one or more bits from its reference is a mismatch. The first mismatch of a sweep sets fail_o and records its address and the XOR of expected and read data. Later mismatches leave these records unchanged.
- R9: stop_on_fail_i is sampled together with start_i. If it was high, the sweep ends at the first mismatch. If it was low, the sweep continues to the last address.
- R10: err_count_o counts mismatching locations in the current sweep and holds at its all-ones maximum.
- R11: done_o is high for exactly one cycle. That cycle follows the edge on which the final read was taken, and busy_o falls at the same edge.
- R12: Between the end of a sweep and the next accepted start, fail_o, fail_addr_o, fail_bits_o and err_count_o hold their values. Repeating a sweep over an unchanged memory gives an identical report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| pattern_i | input | 2 | Image code (0 erased, 1 checkerboard, 2 diagonal, 3 dense diagonal) |
| stop_on_fail_i | input | 1 | End the sweep at the first mismatch |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_valid_i | input | 1 | Read data valid for the current request |
| mem_data_i | input | 8 | Read data |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| fail_o | output | 1 | At least one mismatch in the last or current sweep |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_bits_o | output | 8 | Differing bits at the first mismatch |
| err_count_o | output | COUNT_W | Saturating count of mismatching locations |

## Verification
The assertions assume that the memory side raises mem_valid_i only for the address currently presented, and that it may answer in the same cycle as the request or some cycles later. They also assume that reset is held for at least one clock edge, and that ADDR_W is at least 5 so that the dense image can use its address bits. The bench responder answers with a latency that cycles through 0, 1 and 2 cycles. It raises mem_valid_i with junk data on alternate idle cycles, which exercises the rule that valid is ignored outside a request. It inserts a start request with a different image part-way through a sweep.

// File: rtl/mpv_pkg.sv
package mpv_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PAT_ERASED  = 2'd0,
        PAT_CHECKER = 2'd1,
        PAT_DIAG    = 2'd2,
        PAT_DENSE   = 2'd3
    } pat_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } state_e;

endpackage

// File: rtl/mpv_pattern_gen.sv
// Reference byte for one address, built lane by lane.
module mpv_pattern_gen
    import mpv_pkg::*;
(
    input  pat_e              pat_i,
    input  logic [4:0]        lo_addr_i,   // address bits [4:0]
    input  logic              row_bit_i,   // address bit ROW_BIT
    output logic [BYTE_W-1:0] expect_o
);

    logic              chk_sel;
    logic [BYTE_W-1:0] chk_byte;
    logic [BYTE_W-1:0] diag_byte;
    logic [BYTE_W-1:0] dense_byte;
    logic              dense_row;

    assign chk_sel   = lo_addr_i[0] ^ row_bit_i;
    assign dense_row = (lo_addr_i[1:0] == 2'b00);

    for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
        // even lanes carry the inverse of the select, odd lanes the select
        if (b % 2 == 0) begin : g_even
            assign chk_byte[b] = ~chk_sel;
        end else begin : g_odd
            assign chk_byte[b] = chk_sel;
        end
        assign diag_byte[b]  = (lo_addr_i[2:0] != 3'(b));
        assign dense_byte[b] = ~(dense_row && (lo_addr_i[4:2] == 3'(b)));
    end

    always_comb begin
        unique case (pat_i)
            PAT_ERASED:  expect_o = '1;
            PAT_CHECKER: expect_o = chk_byte;
            PAT_DIAG:    expect_o = diag_byte;
            PAT_DENSE:   expect_o = dense_byte;
            default:     expect_o = '1;
        endcase
    end

endmodule

// File: rtl/mpv_mismatch.sv
// Bitwise difference between reference and read data.
module mpv_mismatch
    import mpv_pkg::*;
(
    input  logic [BYTE_W-1:0] expect_i,
    input  logic [BYTE_W-1:0] actual_i,
    output logic [BYTE_W-1:0] diff_o,
    output logic              any_o
);

    assign diff_o = expect_i ^ actual_i;
    assign any_o  = |diff_o;

endmodule

// File: rtl/mpv_sat_counter.sv
// Error counter that stops at its all-ones value.
module mpv_sat_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               inc_i,
    output logic [COUNT_W-1:0] count_o
);

    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic [COUNT_W-1:0] count_d;
    logic [COUNT_W-1:0] count_q;

    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (inc_i && (count_q != CNT_MAX)) begin
            count_d = count_q + COUNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/mem_pattern_verifier.sv
// Sweeps a byte-wide memory and compares it with a generated image.
module mem_pattern_verifier
    import mpv_pkg::*;
#(
    parameter int ADDR_W  = 10,  // at least 5
    parameter int ROW_BIT = 5,   // address bit that flips the checkerboard per row
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         pattern_i,
    input  logic               stop_on_fail_i,
    output logic               mem_req_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic               mem_valid_i,
    input  logic [BYTE_W-1:0]  mem_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [ADDR_W-1:0]  fail_addr_o,
    output logic [BYTE_W-1:0]  fail_bits_o,
    output logic [COUNT_W-1:0] err_count_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        state_e              state;
        logic [ADDR_W-1:0]   addr;
        pat_e                pat;
        logic                stop;
        logic                fail;
        logic [ADDR_W-1:0]   faddr;
        logic [BYTE_W-1:0]   fbits;
        logic                done;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic [BYTE_W-1:0] exp_byte;
    logic [BYTE_W-1:0] diff_bits;
    logic              diff_any;
    logic              take_start;
    logic              take_read;

    assign take_start = (r_q.state == ST_IDLE) && start_i;
    assign take_read  = (r_q.state == ST_SWEEP) && mem_valid_i;

    mpv_pattern_gen u_gen (
        .pat_i     (r_q.pat),
        .lo_addr_i (r_q.addr[4:0]),
        .row_bit_i (r_q.addr[ROW_BIT]),
        .expect_o  (exp_byte)
    );

    mpv_mismatch u_cmp (
        .expect_i (exp_byte),
        .actual_i (mem_data_i),
        .diff_o   (diff_bits),
        .any_o    (diff_any)
    );

    mpv_sat_counter #(
        .COUNT_W (COUNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (take_start),
        .inc_i   (take_read && diff_any),
        .count_o (err_count_o)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_SWEEP;
                    r_d.addr  = '0;
                    r_d.pat   = pat_e'(pattern_i);
                    r_d.stop  = stop_on_fail_i;
                    r_d.fail  = 1'b0;
                    r_d.faddr = '0;
                    r_d.fbits = '0;
                end
            end
            ST_SWEEP: begin
                if (mem_valid_i) begin
                    if (diff_any && !r_q.fail) begin
                        r_d.fail  = 1'b1;
                        r_d.faddr = r_q.addr;
                        r_d.fbits = diff_bits;
                    end
                    if ((diff_any && r_q.stop) || (r_q.addr == LAST_ADDR)) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.addr = r_q.addr + ADDR_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o   = (r_q.state == ST_SWEEP);
    assign mem_addr_o  = r_q.addr;
    assign busy_o      = (r_q.state == ST_SWEEP);
    assign done_o      = r_q.done;
    assign fail_o      = r_q.fail;
    assign fail_addr_o = r_q.faddr;
    assign fail_bits_o = r_q.fbits;

endmodule

// File: rtl/mpv_checker.sv
module mpv_checker #(
    parameter int ADDR_W  = 10,
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req_o,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic               mem_valid_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               fail_o,
    input logic [ADDR_W-1:0]  fail_addr_o,
    input logic [7:0]         fail_bits_o,
    input logic [COUNT_W-1:0] err_count_o
);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req_o && mem_valid_i) && mem_req_o)
            |-> ((mem_addr_o - $past(mem_addr_o)) == ADDR_W'(1)));

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ((mem_addr_o == '0) && !fail_o && (err_count_o == '0)));

    assert_first_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fail_o) && $past(busy_o) && busy_o)
            |-> (fail_o && $stable(fail_addr_o) && $stable(fail_bits_o)));

    assert_count_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> (err_count_o >= $past(err_count_o)));

    assert_fail_counted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (err_count_o != '0));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o))
            |-> ($stable(fail_o) && $stable(err_count_o) && $stable(fail_addr_o)));

endmodule

bind mem_pattern_verifier mpv_checker #(
    .ADDR_W  (ADDR_W),
    .COUNT_W (COUNT_W)
) u_mpv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_bits_o (fail_bits_o),
    .err_count_o (err_count_o)
);

// File: tb/mem_pattern_verifier_bench.sv
`timescale 1ns/100ps
module mem_pattern_verifier_bench;

    localparam int AW   = 6;
    localparam int NLOC = 1 << AW;
    localparam int RB   = 3;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    pattern_i = 2'd0;
    logic          stop_on_fail_i = 1'b0;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_valid_i = 1'b0;
    logic [7:0]    mem_data_i = 8'h00;
    logic          busy_o;
    logic          done_o;
    logic          fail_o;
    logic [AW-1:0] fail_addr_o;
    logic [7:0]    fail_bits_o;
    logic [CW-1:0] err_count_o;

    always #2.5 clk = ~clk;

    mem_pattern_verifier #(.ADDR_W(AW), .ROW_BIT(RB), .COUNT_W(CW)) u_mem_pattern_verifier (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pattern_i(pattern_i),
        .stop_on_fail_i(stop_on_fail_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o),
        .fail_bits_o(fail_bits_o), .err_count_o(err_count_o)
    );

    logic [7:0] mem [NLOC];
    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit timed_out = 0;
    int wait_ctr = 0;
    int lat = 0;

    // behavioural model state
    bit m_busy = 0, m_done = 0, m_fail = 0, m_stop = 0;
    int m_addr = 0, m_faddr = 0, m_fbits = 0, m_cnt = 0, m_pat = 0;

    function automatic int ref_byte(int pat, int a);
        case (pat)
            0: return 8'hFF;
            1: return (((a % 2) + ((a >> RB) % 2)) % 2 == 1) ? 8'hAA : 8'h55;
            2: return 8'hFF & ~(1 << (a % 8));
            default: return (a % 4 == 0) ? (8'hFF & ~(1 << ((a / 4) % 8))) : 8'hFF;
        endcase
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R11 busy_o", busy_o, m_busy);
        chk("R3 mem_req_o", mem_req_o, m_busy);
        if (m_busy) chk("R3 mem_addr_o", mem_addr_o, m_addr);
        chk("R11 done_o", done_o, m_done);
        chk("R8 fail_o", fail_o, m_fail);
        chk("R8 fail_addr_o", fail_addr_o, m_faddr);
        chk("R8 fail_bits_o", fail_bits_o, m_fbits);
        chk("R10 err_count_o", err_count_o, m_cnt);
    endtask

    task automatic model_step();
        int x;
        m_done = 0;
        if (!m_busy) begin
            if (start_i) begin
                m_busy = 1; m_addr = 0; m_fail = 0; m_faddr = 0; m_fbits = 0;
                m_cnt = 0; m_pat = pattern_i; m_stop = stop_on_fail_i;
            end
        end else if (mem_valid_i) begin
            x = ref_byte(m_pat, m_addr) ^ mem_data_i;
            if (x != 0) begin
                if (m_cnt < CMAX) m_cnt++;
                if (!m_fail) begin m_fail = 1; m_faddr = m_addr; m_fbits = x; end
            end
            if ((x != 0 && m_stop) || m_addr == NLOC - 1) begin
                m_busy = 0; m_done = 1;
            end else begin
                m_addr++;
            end
        end
    endtask

    // one cycle: check outputs at the falling edge, drive inputs, advance model
    task automatic tick(bit st, logic [1:0] pat, bit stop);
        compare_all();
        start_i = st; pattern_i = pat; stop_on_fail_i = stop;
        if (mem_req_o) begin
            if (wait_ctr >= lat) begin
                mem_valid_i = 1'b1;
                mem_data_i  = mem[mem_addr_o];
                wait_ctr = 0;
                lat = (lat + 1) % 3;
            end else begin
                mem_valid_i = 1'b0;
                mem_data_i  = 8'h00;
                wait_ctr++;
            end
        end else begin
            // junk response while idle (R3: must be ignored)
            mem_valid_i = cycles[0];
            mem_data_i  = 8'h3C;
        end
        model_step();
        cycles++;
        if (cycles > WATCHDOG && !timed_out) begin
            timed_out = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(int pat, bit stop, bit inject);
        int n = 0;
        tick(1'b1, 2'(pat), stop);
        while (!done_o && !timed_out) begin
            // R2: a start with a different image during the sweep is ignored
            if (inject && n == 5) tick(1'b1, 2'(pat + 1), ~stop);
            else tick(1'b0, 2'd0, 1'b0);
            n++;
        end
    endtask

    task automatic fill_ref(int pat);
        for (int a = 0; a < NLOC; a++) mem[a] = 8'(ref_byte(pat, a));
    endtask

    task automatic fill_const(logic [7:0] v);
        for (int a = 0; a < NLOC; a++) mem[a] = v;
    endtask

    task automatic report(string tag, int f, int fa, int fb, int c);
        chk({tag, " fail"}, fail_o, f);
        chk({tag, " addr"}, fail_addr_o, fa);
        chk({tag, " bits"}, fail_bits_o, fb);
        chk({tag, " count"}, err_count_o, c);
    endtask

    initial begin
        int ones;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 req", mem_req_o, 0);
        report("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 erased image passes, R2 mid-sweep start ignored
        fill_ref(0);
        sweep(0, 0, 1);
        report("R4 R2 erased pass", 0, 0, 0, 0);

        // R5 checkerboard passes; then R8 two corrupt cells, first one kept
        fill_ref(1);
        sweep(1, 0, 0);
        report("R5 checker pass", 0, 0, 0, 0);
        mem[10] ^= 8'h04;
        mem[20] ^= 8'h80;
        sweep(1, 0, 0);
        report("R8 first mismatch", 1, 10, 8'h04, 2);
        // R12: idle hold and identical repeat
        repeat (6) tick(1'b0, 2'd3, 1'b1);
        report("R12 held", 1, 10, 8'h04, 2);
        sweep(1, 0, 0);
        report("R12 repeat", 1, 10, 8'h04, 2);

        // R5 phase: constant 0x55 first fails at address 1
        fill_const(8'h55);
        sweep(1, 1, 0);
        report("R5 R9 const 55", 1, 1, 8'hFF, 1);

        // R6 diagonal passes; R9 stop at address 5, later error never reached
        fill_ref(2);
        sweep(2, 0, 0);
        report("R6 diag pass", 0, 0, 0, 0);
        mem[5]  ^= 8'h01;
        mem[30] ^= 8'h10;
        sweep(2, 1, 0);
        report("R9 stop early", 1, 5, 8'h01, 1);

        // R6 R10: all 0xFF against diagonal, every location fails, count saturates
        fill_const(8'hFF);
        sweep(2, 0, 0);
        report("R6 R10 saturate", 1, 0, 8'h01, CMAX);

        // R7 dense image: density and position
        ones = 0;
        for (int a = 0; a < NLOC; a++) ones += $countones(8'(ref_byte(3, a)));
        chk("R7 density>95pct", (ones * 100 > 95 * NLOC * 8) ? 1 : 0, 1);
        fill_ref(3);
        sweep(3, 0, 0);
        report("R7 dense pass", 0, 0, 0, 0);
        fill_const(8'hFF);
        mem[0] = 8'hFE;
        sweep(3, 1, 0);
        report("R7 dense position", 1, 4, 8'h02, 1);

        // R11: error only at the last address
        fill_ref(0);
        mem[NLOC-1] = 8'h7F;
        sweep(0, 0, 0);
        report("R11 last addr", 1, NLOC - 1, 8'h80, 1);
        tick(1'b0, 2'd0, 1'b0);
        chk("R11 done one cycle", done_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule